// File: doc/BRIEF.md
# Control Register Mode Tracker

This block keeps the two main control registers of an x86-style core (the "system control" word, CR0, and the "feature control" word, CR4) together with the long-mode enable and no-execute enable bits. Every accepted write also updates a set of hidden mode flags in the same clock edge. These flags are protection enable, segment-base addition, the three FPU trap mirrors and the extended-state save enable. Downstream logic reads the flags directly, so it never decodes the raw register bits itself.

Setting or clearing the paging bit can switch the core into or out of long mode in a single step. A switch into long mode is accepted only when physical address extension is on in CR4. A switch out of long mode clears the 64-bit code flag and cuts the tracked instruction pointer down to 32 bits. Any write that changes a bit that affects address translation raises a one-cycle flush request toward the translation caches.

Top module: `ctlreg_mode_track`

## Requirements
- R1: After synchronous reset, CR0 reads 0x60000010, CR4 reads 0, the long-mode active flag is 0, protection enable is 0, segment-base addition is 1, the MP/EM/TS mirrors are 0, the save-enable flag is 0, the 64-bit code flag is 0 and the flush output is 0.
- R2: A CR0 or CR4 write strobe takes effect on the rising edge at which it is sampled. Stored CR0 always has bit 4 set, whatever value was written.
- R3: An accepted CR0 write that changes bit 31 (paging), bit 16 (write protect) or bit 0 (protection enable) raises the flush output for exactly the one cycle after the write edge. A write that changes none of these bits leaves the flush output low.
- R4: A CR0 write that takes bit 31 from 0 to 1 while the long-mode enable input is 1 and CR4 bit 5 is 1 sets the long-mode active flag. If the long-mode enable input is 0, the same write leaves the flag at 0.
- R5: A CR0 write that would enter long mode while CR4 bit 5 is 0 is ignored. CR0, all derived flags and the flush output stay unchanged.
- R6: A CR0 write that takes bit 31 from 1 to 0 while long mode is active clears the long-mode active flag and the 64-bit code flag. In the same edge the tracked instruction pointer loads the low 32 bits of its input, zero-extended.
- R7: The protection-enable flag equals CR0 bit 0. The segment-base addition flag is forced to 1 whenever stored bit 0 is 0, and holds its value otherwise.
- R8: The MP, EM and TS flags equal CR0 bits 1, 2 and 3 respectively.
- R9: A CR4 write that changes bit 7, bit 5 or bit 4 raises the one-cycle flush output. A CR4 write that changes only other bits does not.
- R10: When the SSE-support strap is 0, CR4 bit 9 is stored as 0. The extended-state save flag always equals stored CR4 bit 9.
- R11: Outside a long-mode exit, the 64-bit code flag and the tracked instruction pointer follow their inputs with one cycle of delay. The long-mode and no-execute enable inputs appear registered on their mirror outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cr0_we | input | 1 | CR0 write strobe |
| cr0_wdata | input | 32 | New CR0 value |
| cr4_we | input | 1 | CR4 write strobe |
| cr4_wdata | input | 32 | New CR4 value |
| lme_en | input | 1 | Long-mode enable bit |
| nxe_en | input | 1 | No-execute enable bit |
| sse_strap | input | 1 | Core supports SSE |
| code64_in | input | 1 | 64-bit code flag from the segment logic |
| ip_in | input | 64 | Current instruction pointer |
| cr0_q | output | 32 | Stored CR0 |
| cr4_q | output | 32 | Stored CR4 |
| lma_q | output | 1 | Long mode active |
| lme_q | output | 1 | Registered long-mode enable |
| nxe_q | output | 1 | Registered no-execute enable |
| hf_pe | output | 1 | Protection enable flag |
| hf_addseg | output | 1 | Segment-base addition flag |
| hf_mp | output | 1 | MP mirror |
| hf_em | output | 1 | EM mirror |
| hf_ts | output | 1 | TS mirror |
| hf_osfxsr | output | 1 | Extended-state save enable flag |
| code64_q | output | 1 | 64-bit code flag |
| ip_q | output | 64 | Tracked instruction pointer |
| flush_q | output | 1 | One-cycle translation flush request |

## Verification
A wrong paging-bit state appears on the next CR0 write as a missing or spurious long-mode transition. It also shows as a flush pulse with the wrong value and, on exit, as an instruction pointer that keeps or loses its upper half. A stale hidden flag appears on its output one cycle after the offending write, because each flag is loaded in the same edge as the register bit it mirrors. The directed scenarios cover the following cases, each checked in the first cycle after the write:
- the rejected long-mode entry;
- an accepted entry;
- an exit;
- paging without long-mode enable;
- a CR4 write that touches only the masked save bit.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;
  localparam int CRW      = 32;
  localparam int BIT_PE   = 0;
  localparam int BIT_MP   = 1;
  localparam int BIT_EM   = 2;
  localparam int BIT_TS   = 3;
  localparam int BIT_ET   = 4;
  localparam int BIT_WP   = 16;
  localparam int BIT_PG   = 31;
  localparam int BIT_PSE  = 4;
  localparam int BIT_PAE  = 5;
  localparam int BIT_PGE  = 7;
  localparam int BIT_OSFX = 9;
  localparam logic [CRW-1:0] CR0_RESET = 32'h6000_0010;

  typedef struct packed {
    logic pe;
    logic addseg;
    logic mp;
    logic em;
    logic ts;
  } hflags_t;
endpackage

// File: rtl/ctl0_unit.sv
module ctl0_unit
  import ctlreg_pkg::*;
#(
  parameter int IPW = 64,
  parameter int TRW = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           we,
  input  logic [CRW-1:0] wdata,
  input  logic           lme,
  input  logic           pae,
  input  logic           code64_in,
  input  logic [IPW-1:0] ip_in,
  output logic [CRW-1:0] cr0_q,
  output logic           lma_q,
  output hflags_t        hf_q,
  output logic           code64_q,
  output logic [IPW-1:0] ip_q,
  output logic           chg
);
  localparam logic [CRW-1:0] XMASK = (CRW'(1) << BIT_PG) | (CRW'(1) << BIT_WP) | (CRW'(1) << BIT_PE);
  localparam logic [CRW-1:0] ETBIT = CRW'(1) << BIT_ET;

  logic [CRW-1:0] nxt;
  logic enter, leave, reject, accept;

  always_comb begin
    nxt    = wdata | ETBIT;
    enter  = we && !cr0_q[BIT_PG] && wdata[BIT_PG] && lme;
    reject = enter && !pae;
    leave  = we && cr0_q[BIT_PG] && !wdata[BIT_PG] && lma_q;
    accept = we && !reject;
    chg    = accept && ((nxt & XMASK) != (cr0_q & XMASK));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cr0_q     <= CR0_RESET;
      lma_q     <= 1'b0;
      hf_q.pe   <= CR0_RESET[BIT_PE];
      hf_q.addseg <= 1'b1;
      hf_q.mp   <= CR0_RESET[BIT_MP];
      hf_q.em   <= CR0_RESET[BIT_EM];
      hf_q.ts   <= CR0_RESET[BIT_TS];
      code64_q  <= 1'b0;
      ip_q      <= '0;
    end else begin
      if (accept) begin
        cr0_q       <= nxt;
        hf_q.pe     <= nxt[BIT_PE];
        hf_q.addseg <= hf_q.addseg | ~nxt[BIT_PE];
        hf_q.mp     <= nxt[BIT_MP];
        hf_q.em     <= nxt[BIT_EM];
        hf_q.ts     <= nxt[BIT_TS];
        if (enter) lma_q <= 1'b1;
        if (leave) lma_q <= 1'b0;
      end
      code64_q <= leave ? 1'b0 : code64_in;
      ip_q     <= leave ? IPW'(ip_in[TRW-1:0]) : ip_in;
    end
  end

  AST_PE_MIRROR: assert property (@(posedge clk) disable iff (rst)
    hf_q.pe == cr0_q[BIT_PE]);                                     // R7
  AST_ADDSEG_REAL: assert property (@(posedge clk) disable iff (rst)
    !cr0_q[BIT_PE] |-> hf_q.addseg);                               // R7
  AST_FPU_MIRROR: assert property (@(posedge clk) disable iff (rst)
    {hf_q.ts, hf_q.em, hf_q.mp} == cr0_q[BIT_TS:BIT_MP]);          // R8
  AST_LMA_NEEDS_PG: assert property (@(posedge clk) disable iff (rst)
    lma_q |-> cr0_q[BIT_PG]);                                      // R4
  AST_EXIT_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (we && cr0_q[BIT_PG] && !wdata[BIT_PG] && lma_q) |=> (!lma_q && !code64_q)); // R6
  AST_REJECT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (we && !cr0_q[BIT_PG] && wdata[BIT_PG] && lme && !pae) |=> ($stable(cr0_q) && !lma_q)); // R5
endmodule

// File: rtl/ctl4_unit.sv
module ctl4_unit
  import ctlreg_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           we,
  input  logic [CRW-1:0] wdata,
  input  logic           sse,
  output logic [CRW-1:0] cr4_q,
  output logic           osfx_q,
  output logic           chg
);
  localparam logic [CRW-1:0] XMASK = (CRW'(1) << BIT_PGE) | (CRW'(1) << BIT_PAE) | (CRW'(1) << BIT_PSE);
  localparam logic [CRW-1:0] OSBIT = CRW'(1) << BIT_OSFX;

  logic [CRW-1:0] nxt;

  always_comb begin
    nxt = sse ? wdata : (wdata & ~OSBIT);
    chg = we && ((nxt & XMASK) != (cr4_q & XMASK));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cr4_q  <= '0;
      osfx_q <= 1'b0;
    end else if (we) begin
      cr4_q  <= nxt;
      osfx_q <= nxt[BIT_OSFX];
    end
  end

  AST_OSFX_MIRROR: assert property (@(posedge clk) disable iff (rst)
    osfx_q == cr4_q[BIT_OSFX]);                                    // R10
  AST_OSFX_MASKED: assert property (@(posedge clk) disable iff (rst)
    (we && !sse) |=> !cr4_q[BIT_OSFX]);                            // R10
endmodule

// File: rtl/flush_gen.sv
module flush_gen #(
  parameter int NSRC = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] req,
  output logic            flush_q
);
  always_ff @(posedge clk) begin
    if (rst) flush_q <= 1'b0;
    else     flush_q <= |req;
  end
endmodule

// File: rtl/ctlreg_mode_track.sv
module ctlreg_mode_track
  import ctlreg_pkg::*;
#(
  parameter int IPW = 64,
  parameter int TRW = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cr0_we,
  input  logic [31:0]    cr0_wdata,
  input  logic           cr4_we,
  input  logic [31:0]    cr4_wdata,
  input  logic           lme_en,
  input  logic           nxe_en,
  input  logic           sse_strap,
  input  logic           code64_in,
  input  logic [IPW-1:0] ip_in,
  output logic [31:0]    cr0_q,
  output logic [31:0]    cr4_q,
  output logic           lma_q,
  output logic           lme_q,
  output logic           nxe_q,
  output logic           hf_pe,
  output logic           hf_addseg,
  output logic           hf_mp,
  output logic           hf_em,
  output logic           hf_ts,
  output logic           hf_osfxsr,
  output logic           code64_q,
  output logic [IPW-1:0] ip_q,
  output logic           flush_q
);
  localparam int NSRC = 2;

  hflags_t         hf;
  logic [NSRC-1:0] chg;

  ctl0_unit #(.IPW(IPW), .TRW(TRW)) u_ctl0 (
    .clk(clk), .rst(rst), .we(cr0_we), .wdata(cr0_wdata),
    .lme(lme_en), .pae(cr4_q[BIT_PAE]),
    .code64_in(code64_in), .ip_in(ip_in),
    .cr0_q(cr0_q), .lma_q(lma_q), .hf_q(hf),
    .code64_q(code64_q), .ip_q(ip_q), .chg(chg[0])
  );

  ctl4_unit u_ctl4 (
    .clk(clk), .rst(rst), .we(cr4_we), .wdata(cr4_wdata), .sse(sse_strap),
    .cr4_q(cr4_q), .osfx_q(hf_osfxsr), .chg(chg[1])
  );

  flush_gen #(.NSRC(NSRC)) u_flush (
    .clk(clk), .rst(rst), .req(chg), .flush_q(flush_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lme_q <= 1'b0;
      nxe_q <= 1'b0;
    end else begin
      lme_q <= lme_en;
      nxe_q <= nxe_en;
    end
  end

  assign hf_pe     = hf.pe;
  assign hf_addseg = hf.addseg;
  assign hf_mp     = hf.mp;
  assign hf_em     = hf.em;
  assign hf_ts     = hf.ts;

  AST_FLUSH_CAUSE: assert property (@(posedge clk) disable iff (rst)
    flush_q |-> $past(cr0_we || cr4_we));                          // R3
  AST_ET_SET: assert property (@(posedge clk) disable iff (rst)
    cr0_q[BIT_ET]);                                                // R2
endmodule

// File: tb/test_ctlreg_mode_track.sv
module test_ctlreg_mode_track;
  logic clk = 1'b0;
  logic rst;
  logic cr0_we, cr4_we, lme_en, nxe_en, sse_strap, code64_in;
  logic [31:0] cr0_wdata, cr4_wdata;
  logic [63:0] ip_in;
  logic [31:0] cr0_q, cr4_q;
  logic lma_q, lme_q, nxe_q, hf_pe, hf_addseg, hf_mp, hf_em, hf_ts, hf_osfxsr, code64_q, flush_q;
  logic [63:0] ip_q;
  int errs = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  ctlreg_mode_track i_ctlreg_mode_track (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr0(input logic [31:0] v);
    @(negedge clk); cr0_we = 1'b1; cr0_wdata = v;
    @(negedge clk); cr0_we = 1'b0;
  endtask

  task automatic wr4(input logic [31:0] v);
    @(negedge clk); cr4_we = 1'b1; cr4_wdata = v;
    @(negedge clk); cr4_we = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 cr0", cr0_q, 64'h6000_0010);
    check("R1 cr4", cr4_q, 0);
    check("R1 lma", lma_q, 0);
    check("R1 pe", hf_pe, 0);
    check("R1 addseg", hf_addseg, 1);
    check("R1 fpu", {hf_mp, hf_em, hf_ts}, 0);
    check("R1 osfx", hf_osfxsr, 0);
    check("R1 code64", code64_q, 0);
    check("R1 flush", flush_q, 0);
  endtask

  task automatic t_et_noflush;
    wr0(32'h0);
    check("R2 et forced", cr0_q, 64'h10);
    check("R3 no flush", flush_q, 0);
  endtask

  task automatic t_pe;
    wr0(32'h1);
    check("R2 cr0", cr0_q, 64'h11);
    check("R7 pe", hf_pe, 1);
    check("R7 addseg held", hf_addseg, 1);
    check("R3 flush pe", flush_q, 1);
    @(negedge clk);
    check("R3 flush one cycle", flush_q, 0);
  endtask

  task automatic t_fpu;
    wr0(32'h0000_000B);
    check("R8 mp/em/ts a", {hf_mp, hf_em, hf_ts}, 3'b101);
    wr0(32'h0000_0005);
    check("R8 mp/em/ts b", {hf_mp, hf_em, hf_ts}, 3'b010);
    check("R3 no flush fpu", flush_q, 0);
    wr0(32'h0001_0005);
    check("R3 flush wp", flush_q, 1);
  endtask

  task automatic t_reject;
    lme_en = 1'b1;
    wr0(32'h8001_0015);
    check("R5 cr0 kept", cr0_q, 64'h0001_0015);
    check("R5 lma", lma_q, 0);
    check("R5 no flush", flush_q, 0);
  endtask

  task automatic t_cr4;
    wr4(32'h20);
    check("R9 pae flush", flush_q, 1);
    check("R2 cr4", cr4_q, 64'h20);
    sse_strap = 1'b0;
    wr4(32'h220);
    check("R10 masked", cr4_q, 64'h20);
    check("R10 osfx0", hf_osfxsr, 0);
    check("R9 no flush", flush_q, 0);
    sse_strap = 1'b1;
    wr4(32'h220);
    check("R10 stored", cr4_q, 64'h220);
    check("R10 osfx1", hf_osfxsr, 1);
    check("R9 no flush osfx", flush_q, 0);
    wr4(32'h2A0);
    check("R9 pge flush", flush_q, 1);
  endtask

  task automatic t_lm;
    code64_in = 1'b1; ip_in = 64'hDEAD_BEEF_1234_5678; nxe_en = 1'b1;
    wr0(32'h8001_0015);
    check("R4 lma set", lma_q, 1);
    check("R4 cr0", cr0_q, 64'h8001_0015);
    check("R4 flush", flush_q, 1);
    check("R11 code64", code64_q, 1);
    check("R11 ip", ip_q, 64'hDEAD_BEEF_1234_5678);
    check("R11 mirrors", {lme_q, nxe_q}, 2'b11);
    wr0(32'h0001_0015);
    check("R6 lma clear", lma_q, 0);
    check("R6 code64 clear", code64_q, 0);
    check("R6 ip trunc", ip_q, 64'h0000_0000_1234_5678);
    check("R3 flush exit", flush_q, 1);
    @(negedge clk);
    check("R11 code64 follows", code64_q, 1);
    check("R11 ip follows", ip_q, 64'hDEAD_BEEF_1234_5678);
  endtask

  task automatic t_pg_nolme;
    lme_en = 1'b0;
    wr0(32'h8001_0015);
    check("R4 no lme lma", lma_q, 0);
    check("R3 flush pg", flush_q, 1);
    wr0(32'h0001_0015);
    check("R6 no trunc", ip_q, 64'hDEAD_BEEF_1234_5678);
    check("R6 code64 kept", code64_q, 1);
  endtask

  initial begin
    #20000;
    errs++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; cr0_we = 0; cr4_we = 0; cr0_wdata = 0; cr4_wdata = 0;
    lme_en = 0; nxe_en = 0; sse_strap = 1; code64_in = 0; ip_in = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_et_noflush;
    t_pe;
    t_fpu;
    t_reject;
    t_cr4;
    t_lm;
    t_pg_nolme;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule